// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block connects a 64-bit register file datapath to a memory that is eight bytes wide. For a load it picks the bytes that an access of one, two, four or eight bytes addresses out of the memory doubleword. It moves them to the low end of the result and fills the rest of the result with copies of the sign bit or with zeros. For a store it moves the low bytes of the register onto the memory byte lanes that the access covers, and it produces one write enable for each lane. Byte order is chosen per request, so little-endian and big-endian accesses can follow each other on consecutive cycles.

A request is offered by raising `req_valid` for one cycle together with its fields. The low address bits give the offset inside the doubleword, and the memory doubleword arrives on `mem_rdata` in the same cycle. The unit never applies back-pressure: it accepts a request on every clock edge where `req_valid` is high and returns results in request order. Store lane data and enables are combinational, so memory can write them on the same edge. Load results are registered. Any access that does not fit its size boundary is refused and reported.

Top module: `lsu_lane_align`

## Requirements
- R1: `req_size` encodes the access width as 0 = byte, 1 = half word (2 bytes), 2 = word (4 bytes), 3 = double word (8 bytes).
- R2: An access of n bytes is misaligned when `req_addr_lo` (offset 0..7) is not a multiple of n. One cycle after such a request, `misalign` is high for exactly one cycle and `ld_valid` stays low.
- R3: A misaligned store drives `mem_be` to all zeros.
- R4: In little-endian mode (`req_big_endian`=0), a load places the byte at offset `req_addr_lo` in result bits [7:0], and the byte at offset `req_addr_lo`+k in result bits [8k+7:8k].
- R5: In big-endian mode (`req_big_endian`=1), a load of n bytes places the byte at offset `req_addr_lo` in the most significant byte of the n-byte datum, which is result bits [8n-1:8n-8]. The byte at offset `req_addr_lo`+n-1 lands in bits [7:0].
- R6: For byte, half-word and word loads, result bits above the datum are copies of the datum's top bit when `req_signed`=1 and zeros when it is 0. Double-word loads ignore `req_signed`.
- R7: An aligned load accepted on a clock edge sets `ld_valid` high for the following cycle, with `ld_data` holding its result. Loads on consecutive cycles each produce their own result one cycle later. `ld_valid`, `misalign` and `ld_data` reset to zero.
- R8: For an aligned store of n bytes at offset o, `mem_be` has bit i set exactly for lanes o to o+n-1. Lane i carries memory byte offset i, which is `mem_wdata` bits [8i+7:8i].
- R9: In little-endian mode, store byte k of `st_data` (bits [8k+7:8k]) goes to lane o+k.
- R10: In big-endian mode, store byte k of `st_data` goes to lane o+n-1-k, so the datum's most significant byte lands at the lowest address.
- R11: Lanes whose enable is low carry zero on `mem_wdata`. When no store is requested, `mem_be` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle; always accepted |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr_lo | input | 3 | Byte offset of the access within the doubleword |
| req_size | input | 2 | Access width code (R1) |
| req_signed | input | 1 | Sign-extend load result when 1 |
| req_big_endian | input | 1 | Byte order select, 1 = big-endian |
| st_data | input | 64 | Register value to store, datum in the low bytes |
| mem_rdata | input | 64 | Memory doubleword for the load, same cycle as the request |
| mem_wdata | output | 64 | Store data steered onto byte lanes |
| mem_be | output | 8 | Per-lane write enables |
| ld_valid | output | 1 | Load result valid strobe |
| ld_data | output | 64 | Aligned, extended load result |
| misalign | output | 1 | One-cycle misaligned-access flag |

## Verification
On every cycle the assertions check the following. Store enables stay off outside store requests. An enabled store covers exactly as many lanes as its size. A byte store enables the one lane its offset names. A store with no enables is reported as misaligned on the next cycle. The load strobe and the misalign flag never rise together, and each is traced back to a request in the previous cycle. Which byte reaches which position, for either byte order, and the sign or zero fill above the datum depend on data values. The bench scenarios show these by sweeping every size, legal offset and byte order against values computed from the requirements. They also cover back-to-back loads and misaligned accesses of each size.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // number of bytes covered by a size code
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    return 32'd1 << sz;
  endfunction
endpackage

// File: rtl/lsu_misalign_detect.sv
module lsu_misalign_detect #(
  parameter int OFF_W = 3
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic             aligned_o
);
  logic [OFF_W-1:0] low_mask;

  // bit i of the offset must be zero for every i below the size code
  always_comb begin
    for (int i = 0; i < OFF_W; i++) begin
      low_mask[i] = (i < int'(size_i));
    end
  end

  assign aligned_o = ((off_i & low_mask) == '0);
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = LANES * 8
) (
  input  logic [DW-1:0]    mem_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic             sgn_i,
  input  logic             big_i,
  output logic [DW-1:0]    data_o
);
  int unsigned      nbytes;
  logic [OFF_W-1:0] src_lane;
  logic [OFF_W-1:0] top_lane;
  logic             fill_bit;

  always_comb begin
    nbytes   = size_bytes(size_i);
    // lane holding the datum's most significant byte
    top_lane = big_i ? off_i : OFF_W'(int'(off_i) + int'(nbytes) - 1);
    fill_bit = sgn_i && (size_i != SZ_DWORD) && mem_i[int'(top_lane)*8 + 7];
    src_lane = '0;
    data_o   = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(nbytes)) begin
        src_lane = big_i ? OFF_W'(int'(off_i) + int'(nbytes) - 1 - k)
                         : OFF_W'(int'(off_i) + k);
        data_o[k*8 +: 8] = mem_i[int'(src_lane)*8 +: 8];
      end else begin
        data_o[k*8 +: 8] = {8{fill_bit}};
      end
    end
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_lane_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = LANES * 8
) (
  input  logic             en_i,
  input  logic [DW-1:0]    data_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic             big_i,
  output logic [DW-1:0]    wdata_o,
  output logic [LANES-1:0] be_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    int   rel;
    int   nb;
    int   src;
    logic hit;
    always_comb begin
      nb  = int'(size_bytes(size_i));
      rel = j - int'(off_i);
      hit = en_i && (rel >= 0) && (rel < nb);
      src = big_i ? (nb - 1 - rel) : rel;
      if (src < 0 || src >= LANES) src = 0;
      be_o[j]           = hit;
      wdata_o[j*8 +: 8] = hit ? data_i[src*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [OFF_W-1:0] req_addr_lo,
  input  logic [1:0]       req_size,
  input  logic             req_signed,
  input  logic             req_big_endian,
  input  logic [DW-1:0]    st_data,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    mem_wdata,
  output logic [LANES-1:0] mem_be,
  output logic             ld_valid,
  output logic [DW-1:0]    ld_data,
  output logic             misalign
);
  logic          aligned;
  logic          store_go;
  logic          load_go;
  logic [DW-1:0] ld_next;

  lsu_misalign_detect #(.OFF_W(OFF_W)) u_align (
    .off_i     (req_addr_lo),
    .size_i    (req_size),
    .aligned_o (aligned)
  );

  assign store_go = req_valid &&  req_store && aligned;
  assign load_go  = req_valid && !req_store && aligned;

  lsu_load_extract #(.LANES(LANES)) u_load (
    .mem_i  (mem_rdata),
    .off_i  (req_addr_lo),
    .size_i (req_size),
    .sgn_i  (req_signed),
    .big_i  (req_big_endian),
    .data_o (ld_next)
  );

  lsu_store_steer #(.LANES(LANES)) u_store (
    .en_i    (store_go),
    .data_i  (st_data),
    .off_i   (req_addr_lo),
    .size_i  (req_size),
    .big_i   (req_big_endian),
    .wdata_o (mem_wdata),
    .be_o    (mem_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      misalign <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= load_go;
      misalign <= req_valid && !aligned;
      if (load_go) ld_data <= ld_next;
    end
  end
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_store,
  input logic [OFF_W-1:0] req_addr_lo,
  input logic [1:0]       req_size,
  input logic [LANES-1:0] mem_be,
  input logic             ld_valid,
  input logic             misalign
);
  // R11: no enables without a store request
  p_no_be_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_store) |-> (mem_be == '0));

  // R8: enabled store covers exactly its size in lanes
  p_be_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && mem_be != '0) |-> ($countones(mem_be) == (1 << req_size)));

  // R8: byte store enables the lane named by the offset
  p_byte_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'd0) |->
      (mem_be == ({{(LANES-1){1'b0}}, 1'b1} << req_addr_lo)));

  // R3: a store refused with zero enables is flagged next cycle
  p_refused_store_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && mem_be == '0) |=> misalign);

  // R2: load strobe and misalign flag are exclusive
  p_valid_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid && misalign));

  // R7: strobe follows a load request by one cycle
  p_valid_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(req_valid && !req_store));

  // R2: flag follows a request by one cycle
  p_flag_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> $past(req_valid));
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_store   (req_store),
  .req_addr_lo (req_addr_lo),
  .req_size    (req_size),
  .mem_be      (mem_be),
  .ld_valid    (ld_valid),
  .misalign    (misalign)
);

// File: tb/tb_lsu_lane_align.sv
module tb_lsu_lane_align;
  localparam logic [63:0] MEM_PAT = 64'hF1E2_53C4_B5A6_1788;
  localparam logic [63:0] ST_PAT  = 64'h8877_6655_4433_2211;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, req_big_endian = 1'b0;
  logic [2:0]  req_addr_lo = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] st_data = ST_PAT, mem_rdata = MEM_PAT;
  logic [63:0] mem_wdata, ld_data;
  logic [7:0]  mem_be;
  logic        ld_valid, misalign;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  lsu_lane_align dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr_lo(req_addr_lo), .req_size(req_size), .req_signed(req_signed),
    .req_big_endian(req_big_endian), .st_data(st_data), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .ld_valid(ld_valid),
    .ld_data(ld_data), .misalign(misalign)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_load(input logic big, input int n, input int off, input logic sgn);
    logic [63:0] v = '0;
    logic [7:0]  b;
    for (int k = 0; k < n; k++) begin
      b = MEM_PAT[(off + k) * 8 +: 8];
      if (big) v = (v << 8) | 64'(b);
      else     v = v | (64'(b) << (8 * k));
    end
    if (sgn && n < 8 && v[8 * n - 1]) v = v | (~64'd0 << (8 * n));
    return v;
  endfunction

  function automatic logic [63:0] exp_wdata(input logic big, input int n, input int off);
    logic [63:0] w = '0;
    for (int k = 0; k < n; k++) begin
      if (big) w[(off + k) * 8 +: 8] = ST_PAT[(n - 1 - k) * 8 +: 8];
      else     w[(off + k) * 8 +: 8] = ST_PAT[k * 8 +: 8];
    end
    return w;
  endfunction

  function automatic logic [7:0] exp_be(input int n, input int off);
    logic [7:0] m = '0;
    for (int k = 0; k < n; k++) m[off + k] = 1'b1;
    return m;
  endfunction

  task automatic drive(input logic st, input logic big, input int sz, input int off, input logic sgn);
    req_valid = 1'b1; req_store = st; req_big_endian = big;
    req_size = 2'(sz); req_addr_lo = 3'(off); req_signed = sgn;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_store = 1'b0;
  endtask

  // one aligned load, result checked one cycle later
  task automatic do_load(input string req, input logic big, input int sz, input int off, input logic sgn);
    @(negedge clk); drive(1'b0, big, sz, off, sgn);
    @(negedge clk); idle();
    check({req, " ld_valid"}, 64'(ld_valid), 64'd1);
    check({req, " ld_data"}, ld_data, exp_load(big, 1 << sz, off, sgn));
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R7 reset ld_valid", 64'(ld_valid), 64'd0);
    check("R7 reset misalign", 64'(misalign), 64'd0);
    check("R7 reset ld_data", ld_data, 64'd0);
    check("R11 reset mem_be", 64'(mem_be), 64'd0);
  endtask

  // R1 R4 R5 R6: every size, legal offset, order and extension mode
  task automatic t_load_sweep();
    for (int big = 0; big < 2; big++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off += (1 << sz))
          for (int sg = 0; sg < 2; sg++)
            do_load(big != 0 ? "R5 R6 load be" : "R4 R6 load le", big != 0, sz, off, sg != 0);
  endtask

  // R6: known sign cases written out
  task automatic t_extension_cases();
    do_load("R6 byte signed neg", 1'b0, 0, 7, 1'b1);
    check("R6 byte signed value", ld_data, 64'hFFFF_FFFF_FFFF_FFF1);
    do_load("R6 byte zero ext", 1'b0, 0, 7, 1'b0);
    check("R6 byte zero value", ld_data, 64'h0000_0000_0000_00F1);
    do_load("R6 dword signed ignored", 1'b0, 3, 0, 1'b1);
    check("R6 dword value", ld_data, MEM_PAT);
    do_load("R5 half be", 1'b1, 1, 0, 1'b0);
    check("R5 half be value", ld_data, 64'h0000_0000_0000_8817);
  endtask

  // R2: misaligned loads of each size
  task automatic t_load_misaligned();
    int offs[3] = '{1, 2, 4};
    for (int s = 1; s < 4; s++) begin
      @(negedge clk); drive(1'b0, 1'b0, s, offs[s - 1], 1'b0);
      @(negedge clk); idle();
      check("R2 misalign load flag", 64'(misalign), 64'd1);
      check("R2 misalign load no valid", 64'(ld_valid), 64'd0);
      @(negedge clk);
      check("R2 misalign single cycle", 64'(misalign), 64'd0);
    end
  endtask

  // R8 R9 R10 R11: every aligned store
  task automatic t_store_sweep();
    for (int big = 0; big < 2; big++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off += (1 << sz)) begin
          @(negedge clk); drive(1'b1, big != 0, sz, off, 1'b0);
          #1;
          check("R8 store be", 64'(mem_be), 64'(exp_be(1 << sz, off)));
          check(big != 0 ? "R10 R11 store data be" : "R9 R11 store data le",
                mem_wdata, exp_wdata(big != 0, 1 << sz, off));
          @(negedge clk); idle();
          check("R2 aligned store no flag", 64'(misalign), 64'd0);
        end
  endtask

  // R3: misaligned stores leave memory untouched
  task automatic t_store_misaligned();
    for (int s = 1; s < 4; s++) begin
      @(negedge clk); drive(1'b1, 1'b1, s, 3, 1'b0);
      #1;
      check("R3 misalign store be", 64'(mem_be), 64'd0);
      @(negedge clk); idle();
      check("R2 misalign store flag", 64'(misalign), 64'd1);
    end
  endtask

  // R11: store flag without valid writes nothing
  task automatic t_idle_store();
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b1; req_size = 2'd3; req_addr_lo = 3'd0;
    #1;
    check("R11 idle be", 64'(mem_be), 64'd0);
    check("R11 idle wdata", mem_wdata, 64'd0);
    @(negedge clk); idle();
    check("R2 idle no flag", 64'(misalign), 64'd0);
  endtask

  // R7: loads on consecutive cycles
  task automatic t_back_to_back();
    @(negedge clk); drive(1'b0, 1'b0, 2, 4, 1'b1);
    @(negedge clk); drive(1'b0, 1'b1, 1, 6, 1'b0);
    check("R7 b2b first valid", 64'(ld_valid), 64'd1);
    check("R7 b2b first data", ld_data, 64'hFFFF_FFFF_F1E2_53C4);
    @(negedge clk); idle();
    check("R7 b2b second valid", 64'(ld_valid), 64'd1);
    check("R7 b2b second data", ld_data, 64'h0000_0000_0000_E2F1);
    @(negedge clk);
    check("R7 strobe drops", 64'(ld_valid), 64'd0);
    check("R7 data held", ld_data, 64'h0000_0000_0000_E2F1);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_load_sweep();
    t_extension_cases();
    t_load_misaligned();
    t_store_sweep();
    t_store_misaligned();
    t_idle_store();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule